// File: doc/BRIEF.md
# Periodic Tick Interrupt Unit

This block turns rollover strobes from a clock counter chain into host-visible flags and an interrupt. Each of its tick inputs is a one-cycle strobe that fires when one counter of the chain wraps. The intervals run from fractions of a second up to minutes. Every strobe latches its own bit in a tick flag register. These bits collect whether or not an interrupt is wanted, so software can poll them. An access of any kind to that register empties it.

A separate enable register selects which ticks may raise the interrupt, and any subset may be enabled. An enabled tick sets a single sticky summary bit in a status register. That bit drives the interrupt output directly. The summary bit is cleared only by writing a one to it. It is independent of the individual tick flags, and it stays pending even when every enable has since been removed. The host reaches the three registers through a simple register bus with separate read and write strobes. Read data is returned combinationally in the same cycle as the read strobe.

Top module: `tick_irq_unit`

## Requirements
- R1: After reset the tick flags, the enables and the summary bit are all zero, and `irqOut` is low.
- R2: A strobe on `tickStb[i]` sets tick flag bit i from the next cycle on, whether or not bit i is enabled.
- R3: A read of the tick flag register (address 0) returns the flags held before that cycle, with bit i for tick i. It then leaves every flag cleared from the next cycle, unless a new tick arrives.
- R4: A write to the tick flag register clears every flag, and the data written has no effect.
- R5: A tick that arrives in the same cycle as a read or write of the tick flag register leaves its own flag set after the access.
- R6: The enable register (address 1) is read/write with bit i enabling tick i, and any combination may be set. Data bits at and above the tick count are dropped and read as zero.
- R7: A tick whose enable bit is set raises the summary bit (status register address 2, bit 0) and `irqOut` in the next cycle. A tick whose enable is clear does not.
- R8: Writing status with bit 0 set clears the summary bit and `irqOut`, and writing it with bit 0 clear has no effect. Clearing the individual tick flags does not cancel the interrupt.
- R9: Once set, the summary bit stays set after all enables are cleared, until a one is written to it.
- R10: An enabled tick in the same cycle as a write of one to the summary bit leaves the summary bit set.
- R11: Address 3 reads as zero, and writes to it change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| tickStb | input | NUM_TICKS | One-cycle rollover strobes, one per counter |
| regSel | input | 2 | Register address: 0 tick flags, 1 enables, 2 status, 3 unused |
| regRd | input | 1 | Read strobe |
| regWr | input | 1 | Write strobe |
| regWdata | input | DATA_W | Write data |
| regRdata | output | DATA_W | Read data of the addressed register, same cycle |
| irqOut | output | 1 | Periodic interrupt request, high while the summary bit is set |

## Verification
The bench builds the block with its default parameters: six ticks and an 8-bit data bus. With these values, enable writes that carry ones in the two bits above the tick count can be shown to be dropped. Ticks can also be made to collide with flag-register reads and writes, and with writes of one to the summary bit. The tests also cover withdrawing every enable while an interrupt is pending, and clearing the flags while the summary bit stays up.

// File: rtl/tick_irq_pkg.sv
package tick_irq_pkg;

  typedef enum logic [1:0] {
    REG_FLAGS  = 2'd0,
    REG_ENABLE = 2'd1,
    REG_STATUS = 2'd2,
    REG_NONE   = 2'd3
  } regId_e;

  localparam int SUM_BIT = 0;

  typedef struct packed {
    logic   flagClr;
    logic   enWr;
    logic   sumClr;
    regId_e rdSel;
  } ctrlStrobes_t;

endpackage

// File: rtl/tick_irq_ctrl.sv
module tick_irq_ctrl
  import tick_irq_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic [1:0]        regSel,
  input  logic              regRd,
  input  logic              regWr,
  input  logic [DATA_W-1:0] regWdata,
  output ctrlStrobes_t      strobes
);

  regId_e selId;
  logic   anyAccess;

  always_comb begin
    selId     = regId_e'(regSel);
    anyAccess = regRd | regWr;
    strobes.flagClr = anyAccess && (selId == REG_FLAGS);
    strobes.enWr    = regWr && (selId == REG_ENABLE);
    strobes.sumClr  = regWr && (selId == REG_STATUS) && regWdata[SUM_BIT];
    strobes.rdSel   = selId;
  end

endmodule

// File: rtl/tick_irq_datapath.sv
module tick_irq_datapath
  import tick_irq_pkg::*;
#(
  parameter int NUM_TICKS = 6,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_TICKS-1:0] tickStb,
  input  logic [DATA_W-1:0]    regWdata,
  input  ctrlStrobes_t         strobes,
  output logic [NUM_TICKS-1:0] flagQ,
  output logic [NUM_TICKS-1:0] enableQ,
  output logic                 summaryQ,
  output logic [DATA_W-1:0]    regRdata
);

  localparam int PAD_W = DATA_W - NUM_TICKS;

  logic [NUM_TICKS-1:0] flagKeep;
  logic                 sumSet;

  always_comb begin
    flagKeep = strobes.flagClr ? '0 : flagQ;
    sumSet   = |(tickStb & enableQ);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      flagQ    <= '0;
      enableQ  <= '0;
      summaryQ <= 1'b0;
    end else begin
      flagQ <= flagKeep | tickStb;
      if (strobes.enWr) enableQ <= regWdata[NUM_TICKS-1:0];
      summaryQ <= sumSet | (summaryQ & ~strobes.sumClr);
    end
  end

  logic [DATA_W-1:0] flagWord;
  logic [DATA_W-1:0] enableWord;
  logic [DATA_W-1:0] statusWord;

  generate
    if (PAD_W > 0) begin : g_pad
      assign flagWord   = {{PAD_W{1'b0}}, flagQ};
      assign enableWord = {{PAD_W{1'b0}}, enableQ};
    end else begin : g_nopad
      assign flagWord   = flagQ;
      assign enableWord = enableQ;
    end
  endgenerate

  always_comb begin
    statusWord          = '0;
    statusWord[SUM_BIT] = summaryQ;
  end

  always_comb begin
    unique case (strobes.rdSel)
      REG_FLAGS:  regRdata = flagWord;
      REG_ENABLE: regRdata = enableWord;
      REG_STATUS: regRdata = statusWord;
      default:    regRdata = '0;
    endcase
  end

endmodule

// File: rtl/tick_irq_unit.sv
module tick_irq_unit
  import tick_irq_pkg::*;
#(
  parameter int NUM_TICKS = 6,
  parameter int DATA_W    = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [NUM_TICKS-1:0] tickStb,
  input  logic [1:0]           regSel,
  input  logic                 regRd,
  input  logic                 regWr,
  input  logic [DATA_W-1:0]    regWdata,
  output logic [DATA_W-1:0]    regRdata,
  output logic                 irqOut
);

  ctrlStrobes_t         strobes;
  logic [NUM_TICKS-1:0] flagQ;
  logic [NUM_TICKS-1:0] enableQ;
  logic                 summaryQ;

  tick_irq_ctrl #(.DATA_W(DATA_W)) ctrl_i (
    .regSel   (regSel),
    .regRd    (regRd),
    .regWr    (regWr),
    .regWdata (regWdata),
    .strobes  (strobes)
  );

  tick_irq_datapath #(.NUM_TICKS(NUM_TICKS), .DATA_W(DATA_W)) dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .tickStb  (tickStb),
    .regWdata (regWdata),
    .strobes  (strobes),
    .flagQ    (flagQ),
    .enableQ  (enableQ),
    .summaryQ (summaryQ),
    .regRdata (regRdata)
  );

  assign irqOut = summaryQ;

endmodule

// File: rtl/tick_irq_unit_chk.sv
module tick_irq_unit_chk #(
  parameter int NUM_TICKS = 6,
  parameter int DATA_W    = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [NUM_TICKS-1:0] tickStb,
  input logic [1:0]           regSel,
  input logic                 regRd,
  input logic                 regWr,
  input logic [DATA_W-1:0]    regWdata,
  input logic [NUM_TICKS-1:0] flagQ,
  input logic [NUM_TICKS-1:0] enableQ,
  input logic                 summaryQ,
  input logic                 irqOut
);

  logic flagAccess;
  logic sumW1c;
  logic enabledTick;

  assign flagAccess  = (regRd | regWr) && (regSel == 2'd0);
  assign sumW1c      = regWr && (regSel == 2'd2) && regWdata[0];
  assign enabledTick = |(tickStb & enableQ);

  assert_tick_sets_flag_R2: assert property (@(posedge clk) disable iff (!rstN)
    (tickStb != '0) |=> ((flagQ & $past(tickStb)) == $past(tickStb)));

  assert_access_clears_R3: assert property (@(posedge clk) disable iff (!rstN)
    (flagAccess && tickStb == '0) |=> (flagQ == '0));

  assert_enabled_tick_raises_R7: assert property (@(posedge clk) disable iff (!rstN)
    enabledTick |=> (summaryQ && irqOut));

  assert_no_spurious_irq_R7: assert property (@(posedge clk) disable iff (!rstN)
    (!summaryQ && !enabledTick) |=> !irqOut);

  assert_w1c_clears_R8: assert property (@(posedge clk) disable iff (!rstN)
    (sumW1c && !enabledTick) |=> !irqOut);

  assert_summary_sticky_R9: assert property (@(posedge clk) disable iff (!rstN)
    (summaryQ && !sumW1c) |=> summaryQ);

endmodule

bind tick_irq_unit tick_irq_unit_chk #(.NUM_TICKS(NUM_TICKS), .DATA_W(DATA_W)) chk_i (
  .clk      (clk),
  .rstN     (rstN),
  .tickStb  (tickStb),
  .regSel   (regSel),
  .regRd    (regRd),
  .regWr    (regWr),
  .regWdata (regWdata),
  .flagQ    (flagQ),
  .enableQ  (enableQ),
  .summaryQ (summaryQ),
  .irqOut   (irqOut)
);

// File: tb/tick_irq_unit_tb_top.sv
module tick_irq_unit_tb_top;

  localparam int NT = 6;
  localparam int DW = 8;
  localparam logic [1:0] A_FLAGS = 2'd0;
  localparam logic [1:0] A_EN    = 2'd1;
  localparam logic [1:0] A_STAT  = 2'd2;
  localparam logic [1:0] A_NONE  = 2'd3;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [NT-1:0] tickStb = '0;
  logic [1:0]    regSel = '0;
  logic          regRd = 1'b0;
  logic          regWr = 1'b0;
  logic [DW-1:0] regWdata = '0;
  logic [DW-1:0] regRdata;
  logic          irqOut;
  logic          probeIrq = 1'b0;

  always #2 clk = ~clk;

  tick_irq_unit #(.NUM_TICKS(NT), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .tickStb(tickStb), .regSel(regSel),
    .regRd(regRd), .regWr(regWr), .regWdata(regWdata),
    .regRdata(regRdata), .irqOut(irqOut)
  );

  typedef struct {
    bit            isIrq;
    logic [DW-1:0] value;
    string         tag;
  } expItem_t;

  expItem_t expQ[$];
  int testsRun = 0;
  int testsFailed = 0;
  bit finished = 1'b0;

  // Monitor: samples 1 ns after the falling edge, well before the rising edge
  always @(negedge clk) begin
    #1;
    if (regRd || probeIrq) begin
      if (expQ.size() == 0) begin
        testsRun++;
        testsFailed++;
        $display("FAIL scoreboard empty: unexpected sample, actual rdata=%0h irq=%0b expected none",
                 regRdata, irqOut);
      end else begin
        expItem_t it;
        logic [DW-1:0] act;
        it = expQ.pop_front();
        act = it.isIrq ? {{(DW-1){1'b0}}, irqOut} : regRdata;
        testsRun++;
        if (act !== it.value) begin
          testsFailed++;
          $display("FAIL %s: actual %0h expected %0h", it.tag, act, it.value);
        end
      end
    end
  end

  task automatic busOp(input logic [NT-1:0] t, input logic rd, input logic wr,
                       input logic [1:0] sel, input logic [DW-1:0] wd);
    @(negedge clk);
    tickStb = t; regRd = rd; regWr = wr; regSel = sel; regWdata = wd;
    @(negedge clk);
    tickStb = '0; regRd = 1'b0; regWr = 1'b0; regSel = '0; regWdata = '0;
  endtask

  task automatic tick(input logic [NT-1:0] t);
    busOp(t, 1'b0, 1'b0, 2'd0, '0);
  endtask

  task automatic wrReg(input logic [1:0] sel, input logic [DW-1:0] d);
    busOp('0, 1'b0, 1'b1, sel, d);
  endtask

  task automatic wrTick(input logic [1:0] sel, input logic [DW-1:0] d, input logic [NT-1:0] t);
    busOp(t, 1'b0, 1'b1, sel, d);
  endtask

  task automatic rdTick(input logic [1:0] sel, input logic [NT-1:0] t,
                        input logic [DW-1:0] exp, input string tag);
    expItem_t it;
    it.isIrq = 1'b0; it.value = exp; it.tag = tag;
    expQ.push_back(it);
    busOp(t, 1'b1, 1'b0, sel, '0);
  endtask

  task automatic rdReg(input logic [1:0] sel, input logic [DW-1:0] exp, input string tag);
    rdTick(sel, '0, exp, tag);
  endtask

  task automatic irqIs(input logic exp, input string tag);
    expItem_t it;
    it.isIrq = 1'b1; it.value = {{(DW-1){1'b0}}, exp}; it.tag = tag;
    expQ.push_back(it);
    @(negedge clk);
    probeIrq = 1'b1;
    @(negedge clk);
    probeIrq = 1'b0;
  endtask

  initial begin
    #(4 * 20000);
    if (!finished) begin
      testsRun++;
      testsFailed++;
      $display("FAIL watchdog: actual hung expected completion");
      $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    irqIs(1'b0, "R1 irq after reset");
    rdReg(A_STAT, 8'h00, "R1 status after reset");
    rdReg(A_EN, 8'h00, "R1 enables after reset");
    rdReg(A_FLAGS, 8'h00, "R1 flags after reset");

    // R2 flags set with no enables, R7 disabled tick gives no irq
    tick(6'h05);
    irqIs(1'b0, "R7 disabled tick no irq");
    rdReg(A_FLAGS, 8'h05, "R2 flags set while disabled");
    // R3 read cleared them
    rdReg(A_FLAGS, 8'h00, "R3 flags cleared by read");

    // R4 write clears, data ignored
    tick(6'h30);
    wrReg(A_FLAGS, 8'hFF);
    rdReg(A_FLAGS, 8'h00, "R4 flags cleared by write");

    // R5 tick coinciding with read or write
    tick(6'h01);
    rdTick(A_FLAGS, 6'h02, 8'h01, "R5 read returns prior flags");
    rdReg(A_FLAGS, 8'h02, "R5 coincident tick kept on read");
    wrTick(A_FLAGS, 8'h00, 6'h08);
    rdReg(A_FLAGS, 8'h08, "R5 coincident tick kept on write");

    // R6 enable register
    wrReg(A_EN, 8'h2A);
    rdReg(A_EN, 8'h2A, "R6 enable readback");
    wrReg(A_EN, 8'hFF);
    rdReg(A_EN, 8'h3F, "R6 upper enable bits dropped");

    // R7 only enabled ticks raise the summary
    wrReg(A_EN, 8'h04);
    tick(6'h02);
    irqIs(1'b0, "R7 unenabled tick");
    rdReg(A_STAT, 8'h00, "R7 status stays clear");
    tick(6'h04);
    irqIs(1'b1, "R7 enabled tick raises irq");
    rdReg(A_STAT, 8'h01, "R7 summary bit set");
    rdReg(A_FLAGS, 8'h06, "R2 flags accumulate");
    irqIs(1'b1, "R8 flag clear does not cancel irq");

    // R8 write-one-to-clear
    wrReg(A_STAT, 8'hFE);
    irqIs(1'b1, "R8 write zero to bit 0 no effect");
    wrReg(A_STAT, 8'h01);
    irqIs(1'b0, "R8 write one clears irq");
    rdReg(A_STAT, 8'h00, "R8 summary cleared");

    // R9 pending after enables removed
    wrReg(A_EN, 8'h01);
    tick(6'h01);
    wrReg(A_EN, 8'h00);
    irqIs(1'b1, "R9 irq pending with no enables");
    tick(6'h01);
    rdReg(A_STAT, 8'h01, "R9 summary still set");
    wrReg(A_STAT, 8'h01);
    irqIs(1'b0, "R9 cleared by write one");
    tick(6'h3F);
    irqIs(1'b0, "R7 all disabled ticks no irq");
    rdReg(A_FLAGS, 8'h3F, "R2 all six flags");

    // R10 set wins over clear
    wrReg(A_EN, 8'h01);
    wrTick(A_STAT, 8'h01, 6'h01);
    irqIs(1'b1, "R10 tick beats clear from idle");
    wrTick(A_STAT, 8'h01, 6'h01);
    irqIs(1'b1, "R10 tick beats clear while pending");
    rdReg(A_STAT, 8'h01, "R10 summary set");
    wrReg(A_STAT, 8'h01);
    irqIs(1'b0, "R8 clear after R10");

    // R11 unused address
    wrReg(A_NONE, 8'hFF);
    rdReg(A_NONE, 8'h00, "R11 unused address reads zero");
    rdReg(A_EN, 8'h01, "R11 enables untouched");
    rdReg(A_STAT, 8'h00, "R11 status untouched");
    rdReg(A_FLAGS, 8'h01, "R11 flags untouched");
    irqIs(1'b0, "R11 irq untouched");

    repeat (2) @(negedge clk);
    if (expQ.size() != 0) begin
      testsRun++;
      testsFailed++;
      $display("FAIL scoreboard: actual %0d items left expected 0", expQ.size());
    end
    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

endmodule